// File: doc/BRIEF.md
# Three-Wire Serial Register Access Master

This block sits on the host side of a radio transceiver and reaches the transceiver's register file over a three-wire serial link. The link has an active-low select, a serial clock and one shared data line that both ends drive in turn. A single request carries an operation, a 6-bit register address and a data byte. The block turns the request into one select window and returns any byte read back, together with a one-cycle completion pulse.

Three operations exist. A register write sends a header byte and then the data byte. A register read sends a header byte, releases the data line and clocks in one byte from the transceiver. A strobe sends a single command byte with no data phase. The header byte carries the access type in its two top bits and the register address in its six low bits, and every byte travels most significant bit first. A parameter sets the serial clock half-period as a count of system clocks.

Top module: `spi3_reg_master`

## Requirements
- R1: While reset is active and on the first cycle after it: `csn` is 1, `sck` is 0, `sdio_oe` is 0, `busy` is 0, `done` is 0 and `rd_data` is 0.
- R2: A write (`req_op` = 2'b00) shifts out 16 bits MSB first: 2'b00, then `req_addr[5:0]`, then `req_wdata[7:0]`. One bit goes out per `sck` rising edge, and `csn` stays low from acceptance until the frame ends.
- R3: A read (`req_op` = 2'b01) shifts out the header 2'b01 followed by `req_addr[5:0]`. `sdio_oe` is 1 for those 8 rising edges and is 0 for the 8 rising edges that follow.
- R4: During a read the block samples `sdio_in` on each of the last 8 `sck` rising edges, MSB first. When `done` pulses, the byte appears on `rd_data` and stays there.
- R5: A strobe (`req_op` = 2'b10 or 2'b11) shifts out only the 8 bits {1'b1, `req_wdata[6:0]`}, MSB first, and then ends the frame.
- R6: `sdio_out` changes only while `sck` is low and stays constant through every `sck` high phase. `sdio_oe` is 1 on every rising edge of a write or strobe frame.
- R7: Each `sck` low or high phase lasts `HALF_CYC` clocks. A frame of N bits produces N rising edges, and `done` is seen 2·`HALF_CYC`·N clocks after the accepting edge.
- R8: `busy` rises on the edge that accepts a request. `done` is a one-cycle pulse. On that same edge `csn` returns high, `sck` is low and `busy` falls.
- R9: A request presented while `busy` is 1 is ignored. The current frame's bits do not change, and no further frame follows.
- R10: If a request is held valid through `done`, it is accepted on the next clock edge, so `csn` stays high for exactly one cycle between the two frames.
- R11: Write and strobe frames leave `rd_data` unchanged.
- R12: While `csn` is high, `sck` is low and `sdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 00 write, 01 read, 1x strobe |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Write data, or command bits [6:0] for a strobe |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Last byte read |
| csn | output | 1 | Active-low select |
| sck | output | 1 | Serial clock |
| sdio_out | output | 1 | Data line drive value |
| sdio_oe | output | 1 | Data line drive enable |
| sdio_in | input | 1 | Data line input value |

## Verification
Two events can land in the same cycle: the end of one frame and the acceptance of the next request. The bench provokes this by holding `req_valid` high through `done`. It then checks that `csn` rises for exactly one cycle and that the second frame starts cleanly. A related collision occurs when a request arrives partway through a frame. The bench judges it by comparing the frame's shifted bits, which must be unchanged, and by confirming that the line stays idle afterwards. Sweeps over every address for each operation compare the captured serial bits, the phase timing and the read byte against values the bench computes itself.

// File: rtl/spi3_pkg.sv
// Package: shared types for the three-wire register master.
// Assumes the request op field is two bits wide; codes 2 and 3 both mean strobe.
package spi3_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_READ   = 2'b01,
        OP_STROBE = 2'b10,
        OP_STB_B  = 2'b11
    } spi3_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10
    } spi3_state_e;

endpackage

// File: rtl/spi3_half_timer.sv
// Module: half-period timer for the serial clock.
// Counts system clocks while run is high and raises tick on the last
// clock of each HALF_CYC-long phase. Assumes HALF_CYC >= 1.
module spi3_half_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    // Tick on the final clock of a phase
    assign tick = run && (cnt == LAST);

    // Phase counter: cleared when idle or at the end of a phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R7

    generate
        if (HALF_CYC > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R7
        end
    endgenerate

endmodule

// File: rtl/spi3_frame_ctrl.sv
// Module: frame sequencer for the three-wire register master.
// Accepts one request when idle, builds the header and data bits, walks
// them out over low/high serial clock phases on phase ticks, releases the
// data line for the read data phase and captures the returned byte.
// Assumes DATA_W >= ADDR_W + 1 so a strobe command fits in the data field.
module spi3_frame_ctrl
    import spi3_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              sdio_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              csn,
    output logic              sck,
    output logic              sdio_out,
    output logic              sdio_oe
);
    localparam int HDR_W   = ADDR_W + 2;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int IW      = $clog2(FRAME_W + 1);
    localparam logic [IW-1:0] HDR_LAST   = IW'(HDR_W - 1);
    localparam logic [IW-1:0] FRAME_LAST = IW'(FRAME_W - 1);
    localparam logic [IW-1:0] HDR_CNT    = IW'(HDR_W);

    spi3_state_e       state;
    logic [FRAME_W-1:0] tx_sr;
    logic [DATA_W-1:0]  rx_sr;
    logic [DATA_W-1:0]  rd_q;
    logic [IW-1:0]      bit_idx;
    logic [IW-1:0]      last_idx;
    logic               is_rd;
    logic               csn_q, sck_q, oe_q, done_q;
    spi3_op_e           op_in;
    logic [FRAME_W-1:0] load_bits;
    logic [IW-1:0]      load_last;

    // Decode the incoming op code
    assign op_in = spi3_op_e'(req_op);

    // Build the bit pattern and length for a new frame
    always_comb begin
        unique case (op_in)
            OP_WRITE: begin
                load_bits = {2'b00, req_addr, req_wdata};
                load_last = FRAME_LAST;
            end
            OP_READ: begin
                load_bits = {2'b01, req_addr, {DATA_W{1'b0}}};
                load_last = FRAME_LAST;
            end
            default: begin
                load_bits = {1'b1, req_wdata[HDR_W-2:0], {DATA_W{1'b0}}};
                load_last = HDR_LAST;
            end
        endcase
    end

    // Frame sequencer: accept, shift out, sample in, close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rd_q     <= '0;
            bit_idx  <= '0;
            last_idx <= '0;
            is_rd    <= 1'b0;
            csn_q    <= 1'b1;
            sck_q    <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_LOW;
                        tx_sr    <= load_bits;
                        last_idx <= load_last;
                        bit_idx  <= '0;
                        is_rd    <= (op_in == OP_READ);
                        csn_q    <= 1'b0;
                        sck_q    <= 1'b0;
                        oe_q     <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sck_q <= 1'b1;
                        state <= ST_HIGH;
                        if (is_rd && bit_idx >= HDR_CNT)
                            rx_sr <= {rx_sr[DATA_W-2:0], sdio_in};
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sck_q <= 1'b0;
                        if (bit_idx == last_idx) begin
                            state  <= ST_IDLE;
                            csn_q  <= 1'b1;
                            oe_q   <= 1'b0;
                            done_q <= 1'b1;
                            if (is_rd) rd_q <= rx_sr;
                        end else begin
                            state   <= ST_LOW;
                            bit_idx <= bit_idx + 1'b1;
                            tx_sr   <= tx_sr << 1;
                            if (is_rd && bit_idx == HDR_LAST) oe_q <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs from the registers
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign rd_data  = rd_q;
    assign csn      = csn_q;
    assign sck      = sck_q;
    assign sdio_out = tx_sr[FRAME_W-1];
    assign sdio_oe  = oe_q;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        csn_q |-> (!sck_q && !oe_q)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($rose(csn_q) && state == ST_IDLE)); // R8
    AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(tx_sr[FRAME_W-1])); // R6
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !csn_q && bit_idx >= HDR_CNT) |-> !oe_q); // R3
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx_sr)); // R9

endmodule

// File: rtl/spi3_reg_master.sv
// Module: top of the three-wire register access master.
// Joins the phase timer and the frame sequencer. Assumes the pad logic
// outside uses sdio_oe to choose between driving sdio_out and reading sdio_in.
module spi3_reg_master #(
    parameter int HALF_CYC = 2,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              csn,
    output logic              sck,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              sdio_in
);
    logic tick;
    logic busy_w;

    spi3_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .tick  (tick)
    );

    spi3_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sdio_in   (sdio_in),
        .busy      (busy_w),
        .done      (done),
        .rd_data   (rd_data),
        .csn       (csn),
        .sck       (sck),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe)
    );

    // Expose the busy state
    assign busy = busy_w;

endmodule

// File: tb/tb_spi3_reg_master.sv
module tb_spi3_reg_master;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, csn, sck, sdio_out, sdio_oe;
    logic [7:0] rd_data;
    logic       sdio_in = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] last_rd = 8'h00;

    always #4 clk = ~clk;

    spi3_reg_master #(.HALF_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .csn(csn), .sck(sck), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .sdio_in(sdio_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: drive (unless pre), follow it to done, compare.
    task automatic do_frame(input logic [1:0] op, input logic [5:0] addr, input logic [7:0] wd,
                            input logic [7:0] sb, input bit keep, input bit pre, input bit poke);
        int nbits;
        int rises = 0;
        int cyc = 0;
        logic [15:0] got = '0;
        logic [15:0] exp_bits;
        bit csn_bad = 0, oe_bad = 0, hold_bad = 0;
        logic prev_sck, prev_out;
        bit exp_oe;
        nbits = op[1] ? 8 : 16;
        case (op)
            2'b00:   exp_bits = {2'b00, addr, wd};
            2'b01:   exp_bits = {8'h00, 2'b01, addr};
            default: exp_bits = {8'h00, 1'b1, wd[6:0]};
        endcase
        if (!pre) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
            @(negedge clk);
        end
        if (!keep) req_valid = 1'b0;
        check(busy == 1'b1 && csn == 1'b0, "R8 accept", {busy, csn}, 2'b10);
        prev_sck = sck; prev_out = sdio_out;
        while (!done && cyc < 4000) begin
            if (sck && !prev_sck) begin
                got = {got[14:0], sdio_out};
                rises++;
                exp_oe = (op == 2'b01) ? (rises <= 8) : 1'b1;
                if (sdio_oe != exp_oe) oe_bad = 1;
            end
            if (sck && prev_sck && sdio_out != prev_out) hold_bad = 1;
            if (csn) csn_bad = 1;
            if (!sdio_oe && rises >= 8 && rises < 16) sdio_in = sb[15 - rises];
            if (poke && cyc == 5) begin
                req_valid = 1'b1; req_op = 2'b10; req_wdata = 8'h55; req_addr = 6'h2A;
            end
            if (poke && cyc == 8) req_valid = 1'b0;
            prev_sck = sck; prev_out = sdio_out;
            @(negedge clk);
            cyc++;
        end
        check(cyc == 2 * H * nbits, "R7 frame length", cyc, 2 * H * nbits);
        check(rises == nbits, "R7 rising edges", rises, nbits);
        if (op == 2'b00)      check(got == exp_bits, "R2 write bits", got, exp_bits);
        else if (op == 2'b01) check(got[15:8] == exp_bits[7:0], "R3 read header", got[15:8], exp_bits[7:0]);
        else                  check(got[7:0] == exp_bits[7:0], "R5 strobe bits", got[7:0], exp_bits[7:0]);
        check(!csn_bad, "R2 csn low in frame", csn_bad, 0);
        check(!oe_bad, (op == 2'b01) ? "R3 oe pattern" : "R6 oe high", oe_bad, 0);
        check(!hold_bad, "R6 data held in high phase", hold_bad, 0);
        check(csn && !busy && !sck, "R8 end of frame", {csn, busy, sck}, 3'b100);
        if (op == 2'b01) begin
            check(rd_data == sb, "R4 read byte", rd_data, sb);
            last_rd = sb;
        end else begin
            check(rd_data == last_rd, "R11 rd_data kept", rd_data, last_rd);
        end
        if (!keep) begin
            @(negedge clk);
            check(!done, "R8 done one cycle", done, 0);
            check(csn && !sck && !sdio_oe, "R12 idle lines", {csn, sck, sdio_oe}, 3'b100);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        check(csn && !sck && !sdio_oe && !busy && !done && rd_data == 8'h00,
              "R1 in reset", {csn, sck, sdio_oe, busy, done, rd_data}, 13'h1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(csn && !sck && !sdio_oe && !busy && !done && rd_data == 8'h00,
              "R1 after reset", {csn, sck, sdio_oe, busy, done, rd_data}, 13'h1000);

        // Sweep every address for each operation
        for (int a = 0; a < 64; a++) begin
            do_frame(2'b00, 6'(a), 8'(a * 37 + 5), 8'h00, 0, 0, 0);
            do_frame(2'b01, 6'(a), 8'(a), 8'(a * 73 + 11), 0, 0, 0);
            do_frame((a % 2 == 0) ? 2'b10 : 2'b11, 6'(63 - a), 8'(a * 2 + 1), 8'h00, 0, 0, 0);
        end
        // Data patterns at the edges of the byte range
        do_frame(2'b01, 6'h3F, 8'h00, 8'hFF, 0, 0, 0);
        do_frame(2'b01, 6'h00, 8'hFF, 8'h00, 0, 0, 0);
        do_frame(2'b00, 6'h3F, 8'hFF, 8'h00, 0, 0, 0);
        do_frame(2'b10, 6'h00, 8'h7F, 8'h00, 0, 0, 0);

        // R9: a request arriving mid-frame changes nothing and starts nothing
        do_frame(2'b00, 6'h15, 8'hA6, 8'h00, 0, 0, 1);
        do_frame(2'b01, 6'h2B, 8'h00, 8'h3C, 0, 0, 1);
        begin
            bit stray = 0;
            repeat (8) begin
                @(negedge clk);
                if (!csn || busy) stray = 1;
            end
            check(!stray, "R9 no frame from ignored request", stray, 0);
        end

        // R10: request held through done is accepted on the next edge
        do_frame(2'b00, 6'h09, 8'hC3, 8'h00, 1, 0, 0);
        @(negedge clk);
        check(!csn && busy && !done, "R10 back-to-back accept", {csn, busy, done}, 3'b010);
        do_frame(2'b00, 6'h09, 8'hC3, 8'h00, 0, 1, 0);
        do_frame(2'b01, 6'h31, 8'h00, 8'h96, 1, 0, 0);
        @(negedge clk);
        check(!csn && busy, "R10 back-to-back read", {csn, busy}, 2'b01);
        do_frame(2'b01, 6'h31, 8'h00, 8'h69, 0, 1, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule